// File: doc/BRIEF.md
# Serial Shadow-RAM Command Interface

This block is the serial slave front end of a small shadow RAM of sixteen 16-bit words. A host drives a chip-enable line, a serial clock, a data-in line and reads a data-out line; the two data lines may be tied together at the host. All four serial inputs are resynchronised into the block's system clock, and serial clock edges are found in that domain. The block therefore stays fully synchronous.

Each transaction starts with an 8-bit instruction. Six of its opcodes act on the block itself. Write-enable and write-disable set and clear a write-enable latch. Read returns one RAM word and write loads one. Sleep is a legacy opcode that is accepted and does nothing. Store and recall are passed on as single-cycle request pulses to a separate sequencer that owns the nonvolatile array. A previous-recall latch, set by a recall command, must be set before a store request is issued.

While the sequencer reports a power-up recall in progress, the block acts on no command. Dropping chip enable ends any transfer at once and puts the interface in standby.

Top module: `ssr_cmd_if`

States: `ST_IDLE` (standby, chip enable low), `ST_CMD` (shifting the instruction), `ST_RD_ARM` (read decoded, waiting for the don't-care 8th rising edge), `ST_RD_LAUNCH` (waiting for the 8th falling edge), `ST_RD_DATA` (driving read data), `ST_WR_DATA` (shifting write data), `ST_DONE` (transfer finished or rejected, waiting for chip enable low).

Transitions:
- IDLE→CMD when chip enable is high.
- CMD→DONE when the first bit is 0.
- CMD→RD_ARM at the 7th rise when the opcode high bits are 11.
- CMD→WR_DATA at the 8th rise for the write opcode.
- CMD→DONE at the 8th rise for any other opcode.
- RD_ARM→RD_LAUNCH on a rise.
- RD_LAUNCH→RD_DATA on a fall.
- RD_DATA→DONE and WR_DATA→DONE on the 16th rise of the data phase.
- Any state→IDLE when chip enable is low.

## Requirements
- R1: An instruction is a start bit of 1, then a 4-bit word address, then a 3-bit operation code, MSB first, sampled on rising serial clock edges. If the first bit is 0, the rest of the transfer is ignored until chip enable goes low.
- R2: Operation codes 110 and 111 read the addressed word. The last instruction bit is a don't-care and does not change the returned word.
- R3: The read word is shifted out MSB first. Bit 15 appears after the falling edge of the 8th serial clock. Each further bit appears after rising edges 9 through 23. The output enable drops after rising edge 24.
- R4: The output enable `sdo_en` is low at all times except while read data is being driven.
- R5: Operation 011 takes the next 16 bits, MSB first, as a word for the addressed location. The word is stored only if the write-enable latch is set; otherwise it is discarded.
- R6: Operation 010 sets the write-enable latch and operation 000 clears it. Reset clears it.
- R7: Operation 101 gives a one-cycle `recall_req` pulse and sets the previous-recall latch. Reset clears that latch.
- R8: Operation 001 gives a one-cycle `store_req` pulse only when both latches are set. Otherwise it has no effect.
- R9: Operation 100 has no effect on the latches, the requests or the RAM.
- R10: While `pur_busy` is high, no instruction changes a latch, issues a request, writes the RAM or drives read data.
- R11: Chip enable low aborts any transfer and returns to standby with the output released. A write cut off before its 16th data bit leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| ce | input | 1 | Serial chip enable, active high |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| pur_busy | input | 1 | Power-up recall in progress, from the sequencer |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_en | output | 1 | Drive enable for sdo; low means high-impedance |
| wen_latch | output | 1 | Write-enable latch |
| recall_latch | output | 1 | Previous-recall latch |
| store_req | output | 1 | One-cycle store request to the sequencer |
| recall_req | output | 1 | One-cycle recall request to the sequencer |

## Verification
If the state machine sits in the wrong state, the first symptom is the output enable: it rises early, rises late, or never falls. This shows within one serial clock of the error. An off-by-one bit counter shifts the read word by one place, visible in the first word read back. A write-enable latch stuck in the wrong value shows only on the next write, store or latch readout. The bench therefore follows every latch command with a readout and every write with a read. Abort and busy cases are checked by reading back locations that must be unchanged.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD_ARM,
        ST_RD_LAUNCH,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_DONE
    } ssr_state_e;

    localparam logic [2:0] OP_WRDS   = 3'b000;
    localparam logic [2:0] OP_STORE  = 3'b001;
    localparam logic [2:0] OP_WREN   = 3'b010;
    localparam logic [2:0] OP_WRITE  = 3'b011;
    localparam logic [2:0] OP_SLEEP  = 3'b100;
    localparam logic [2:0] OP_RECALL = 3'b101;
    localparam logic [1:0] OP_READ_HI = 2'b11;

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i <= STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q    = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/ssr_ram.sv
module ssr_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ssr_cmd_if.sv
module ssr_cmd_if
    import ssr_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sck,
    input  logic sdi,
    input  logic pur_busy,
    output logic sdo,
    output logic sdo_en,
    output logic wen_latch,
    output logic recall_latch,
    output logic store_req,
    output logic recall_req
);
    localparam int CMD_BITS = 1 + ADDR_W + 3;
    localparam int CNT_MAX  = (DATA_W > CMD_BITS) ? DATA_W : CMD_BITS;
    localparam int CNT_W    = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_RD_DEC = CNT_W'(CMD_BITS - 2);
    localparam logic [CNT_W-1:0] CNT_CMD_END = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_DATA_END = CNT_W'(DATA_W - 1);

    logic [2:0] s_q, s_rise, s_fall;
    logic       ce_s, sdi_s, sck_rise, sck_fall;

    ssr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ce, sck, sdi}),
        .q(s_q), .rise(s_rise), .fall(s_fall)
    );

    assign ce_s     = s_q[2];
    assign sdi_s    = s_q[0];
    assign sck_rise = s_rise[1];
    assign sck_fall = s_fall[1];

    ssr_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [CMD_BITS-2:0] cmd_q;
    logic [CMD_BITS-1:0] sh;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wr_sr, rd_sr, ram_rdata;
    logic                ram_we, wen_q, prv_q, sdo_en_q;

    assign sh = {cmd_q, sdi_s};

    ssr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(addr_q),
        .wdata(wr_sr), .raddr(addr_q), .rdata(ram_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (ce_s) state_d = ST_CMD;
            ST_CMD: begin
                if (sck_rise) begin
                    if (cnt_q == '0 && !sdi_s)
                        state_d = ST_DONE;
                    else if (cnt_q == CNT_RD_DEC && sh[1:0] == OP_READ_HI)
                        state_d = pur_busy ? ST_DONE : ST_RD_ARM;
                    else if (cnt_q == CNT_CMD_END)
                        state_d = (sh[2:0] == OP_WRITE && !pur_busy) ? ST_WR_DATA : ST_DONE;
                end
            end
            ST_RD_ARM:    if (sck_rise) state_d = ST_RD_LAUNCH;
            ST_RD_LAUNCH: if (sck_fall) state_d = ST_RD_DATA;
            ST_RD_DATA:   if (sck_rise && cnt_q == CNT_DATA_END) state_d = ST_DONE;
            ST_WR_DATA:   if (sck_rise && cnt_q == CNT_DATA_END) state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
        if (!ce_s) state_d = ST_IDLE;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cmd_q      <= '0;
            addr_q     <= '0;
            wr_sr      <= '0;
            rd_sr      <= '0;
            ram_we     <= 1'b0;
            wen_q      <= 1'b0;
            prv_q      <= 1'b0;
            sdo_en_q   <= 1'b0;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            ram_we     <= 1'b0;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
            if (!ce_s) begin
                cnt_q    <= '0;
                sdo_en_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_CMD: if (sck_rise) begin
                        cmd_q <= sh[CMD_BITS-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_RD_DEC) begin
                            addr_q <= sh[ADDR_W+1:2];
                        end
                        if (cnt_q == CNT_CMD_END) begin
                            cnt_q  <= '0;
                            addr_q <= sh[ADDR_W+2:3];
                            if (!pur_busy) begin
                                unique case (sh[2:0])
                                    OP_WREN:   wen_q <= 1'b1;
                                    OP_WRDS:   wen_q <= 1'b0;
                                    OP_STORE:  store_req <= wen_q & prv_q;
                                    OP_RECALL: begin
                                        recall_req <= 1'b1;
                                        prv_q      <= 1'b1;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                    ST_RD_LAUNCH: if (sck_fall) begin
                        rd_sr    <= ram_rdata;
                        sdo_en_q <= 1'b1;
                        cnt_q    <= '0;
                    end
                    ST_RD_DATA: if (sck_rise) begin
                        if (cnt_q == CNT_DATA_END) begin
                            sdo_en_q <= 1'b0;
                        end else begin
                            rd_sr <= rd_sr << 1;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_WR_DATA: if (sck_rise) begin
                        wr_sr <= {wr_sr[DATA_W-2:0], sdi_s};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_DATA_END) ram_we <= wen_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sdo          = sdo_en_q & rd_sr[DATA_W-1];
    assign sdo_en       = sdo_en_q;
    assign wen_latch    = wen_q;
    assign recall_latch = prv_q;

    // R4: output enable only while in the data-out state
    a_r4_drive_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en_q |-> state_q == ST_RD_DATA);

    // R3: drive starts on a serial clock falling edge
    a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en_q) |-> $past(sck_fall));

    // R11: chip enable low returns to standby with output released
    a_r11_ce_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> (state_q == ST_IDLE && !sdo_en_q));

    // R8: store request only with both latches set
    a_r8_store_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> (wen_q && prv_q));

    // R7: recall request leaves the previous-recall latch set
    a_r7_recall_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> prv_q);

    // R10: busy freezes latches and requests
    a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pur_busy) |-> ($stable(wen_q) && !store_req && !recall_req && !ram_we));

    a_r8_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, recall_req}));
endmodule

// File: tb/tb_ssr_cmd_if.sv
module tb_ssr_cmd_if;
    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sck = 1'b0, sdi = 1'b0, pur_busy = 1'b0;
    logic sdo, sdo_en, wen_latch, recall_latch, store_req, recall_req;

    int n_checks = 0, n_fail = 0, n_store = 0, n_recall = 0;
    bit finished = 1'b0;
    logic [15:0] ref_ram [16];
    logic ref_wen = 1'b0, ref_prv = 1'b0;

    always #5 clk = ~clk;

    ssr_cmd_if dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .sdi(sdi), .pur_busy(pur_busy),
        .sdo(sdo), .sdo_en(sdo_en), .wen_latch(wen_latch), .recall_latch(recall_latch),
        .store_req(store_req), .recall_req(recall_req)
    );

    always @(posedge clk) begin
        if (store_req)  n_store++;
        if (recall_req) n_recall++;
    end

    function automatic logic [7:0] instr(input logic [3:0] a, input logic [2:0] op);
        return {1'b1, a, op};
    endfunction

    function automatic logic [15:0] exp_word(input logic [3:0] a);
        return ref_ram[a];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_cycle(input logic b, output logic r_en, output logic r_do,
                             output logic f_en, output logic f_do);
        sdi = b;
        wclk(4);
        sck = 1'b1;
        wclk(6);
        r_en = sdo_en; r_do = sdo;
        wclk(2);
        sck = 1'b0;
        wclk(6);
        f_en = sdo_en; f_do = sdo;
        wclk(2);
    endtask

    task automatic begin_xfer();
        ce = 1'b1; wclk(4);
    endtask

    task automatic end_xfer();
        ce = 1'b0; sdi = 1'b0; wclk(6);
    endtask

    task automatic send_bits(input logic [7:0] w);
        logic re, rd, fe, fd;
        for (int i = 7; i >= 0; i--) sck_cycle(w[i], re, rd, fe, fd);
    endtask

    task automatic cmd(input logic [2:0] op);
        begin_xfer(); send_bits(instr(4'($urandom), op)); end_xfer();
    endtask

    task automatic write_word(input logic [3:0] a, input logic [15:0] d);
        logic re, rd, fe, fd;
        begin_xfer();
        send_bits(instr(a, 3'b011));
        for (int i = 15; i >= 0; i--) sck_cycle(d[i], re, rd, fe, fd);
        end_xfer();
        if (ref_wen && !pur_busy) ref_ram[a] = d;
    endtask

    // Reads a word; when drive is expected, checks the R3 timing of the enable.
    task automatic read_word(input logic [3:0] a, input logic dc, input bit expect_drive,
                             input string req, output logic [15:0] w);
        logic re, rd, fe, fd;
        logic [7:0] iw;
        iw = {1'b1, a, 2'b11, dc};
        w = '0;
        begin_xfer();
        for (int i = 7; i >= 1; i--) sck_cycle(iw[i], re, rd, fe, fd);
        sck_cycle(iw[0], re, rd, fe, fd);
        check("R3 enable low until 8th fall", {31'd0, re}, 32'd0);
        check({req, " R3 enable after 8th fall"}, {31'd0, fe}, {31'd0, expect_drive});
        w[15] = fd;
        for (int k = 14; k >= 0; k--) begin
            sck_cycle(1'($urandom), re, rd, fe, fd);
            w[k] = rd;
            if (re !== expect_drive) check("R4 enable during data", {31'd0, re}, {31'd0, expect_drive});
        end
        sck_cycle(1'b0, re, rd, fe, fd);
        check("R3 enable dropped after rise 24", {31'd0, re}, 32'd0);
        end_xfer();
    endtask

    task automatic verify(input logic [3:0] a, input string req);
        logic [15:0] w;
        read_word(a, 1'($urandom), 1'b1, req, w);
        check(req, {16'd0, w}, {16'd0, exp_word(a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic re, rd, fe, fd;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) ref_ram[i] = '0;
        wclk(10);
        rst_n = 1'b1;
        wclk(4);

        // Reset state
        check("R4 reset enable", {31'd0, sdo_en}, 32'd0);
        check("R6 reset wen", {31'd0, wen_latch}, 32'd0);
        check("R7 reset prev-recall", {31'd0, recall_latch}, 32'd0);

        // R5: write without enable is discarded
        write_word(4'd3, 16'hA5A5);
        verify(4'd3, "R5 write discarded without wen");

        // R6: write-enable
        cmd(3'b010); ref_wen = 1'b1;
        check("R6 wen set", {31'd0, wen_latch}, 32'd1);

        // R2: read with both don't-care values
        write_word(4'd3, 16'hA5A5);
        read_word(4'd3, 1'b0, 1'b1, "R2 dc=0", w);
        check("R2 read dc=0", {16'd0, w}, 32'h0000A5A5);
        read_word(4'd3, 1'b1, 1'b1, "R2 dc=1", w);
        check("R2 read dc=1", {16'd0, w}, 32'h0000A5A5);
        write_word(4'd15, 16'h8001);
        verify(4'd15, "R3 bit ordering");

        // Random writes and reads
        for (int it = 0; it < 24; it++) begin
            logic [3:0] a;
            a = 4'($urandom);
            if ($urandom % 2) write_word(a, 16'($urandom));
            else verify(a, "R5 random readback");
        end

        // R9: sleep has no effect
        cmd(3'b100);
        check("R9 sleep wen", {31'd0, wen_latch}, 32'd1);
        check("R9 sleep prev-recall", {31'd0, recall_latch}, 32'd0);
        check("R9 sleep requests", n_store + n_recall, 0);
        verify(4'd3, "R9 sleep ram");

        // R8: store blocked without previous recall
        cmd(3'b001);
        check("R8 store blocked", n_store, 0);

        // R7: recall
        cmd(3'b101); ref_prv = 1'b1;
        check("R7 recall pulse", n_recall, 1);
        check("R7 prev-recall set", {31'd0, recall_latch}, 32'd1);

        // R8: store allowed
        cmd(3'b001);
        check("R8 store pulse", n_store, 1);

        // R10: busy blocks everything
        pur_busy = 1'b1;
        cmd(3'b000);
        check("R10 wrds ignored", {31'd0, wen_latch}, 32'd1);
        cmd(3'b101);
        cmd(3'b001);
        check("R10 no requests", n_store + n_recall, 2);
        write_word(4'd3, 16'h1234);
        read_word(4'd3, 1'b0, 1'b0, "R10 read not driven", w);
        pur_busy = 1'b0;
        verify(4'd3, "R10 write ignored");

        // R11: aborted write
        begin_xfer();
        send_bits(instr(4'd3, 3'b011));
        for (int i = 0; i < 10; i++) sck_cycle(1'b1, re, rd, fe, fd);
        end_xfer();
        verify(4'd3, "R11 aborted write");

        // R11: aborted read releases output
        begin_xfer();
        send_bits({1'b1, 4'd3, 3'b110});
        for (int i = 0; i < 3; i++) sck_cycle(1'b0, re, rd, fe, fd);
        check("R11 driving before abort", {31'd0, re}, 32'd1);
        ce = 1'b0; wclk(6);
        check("R11 released after abort", {31'd0, sdo_en}, 32'd0);
        wclk(4);

        // R1: bad start bit ignored
        begin_xfer();
        send_bits({1'b0, 4'd3, 3'b011});
        send_bits(8'hFF); send_bits(8'hFF);
        end_xfer();
        verify(4'd3, "R1 bad start ignored");
        begin_xfer();
        send_bits({1'b0, 4'd0, 3'b000});
        end_xfer();
        check("R1 bad-start wrds ignored", {31'd0, wen_latch}, 32'd1);

        // R6/R8/R5: write-disable
        cmd(3'b000); ref_wen = 1'b0;
        check("R6 wen cleared", {31'd0, wen_latch}, 32'd0);
        cmd(3'b001);
        check("R8 store blocked after wrds", n_store, 1);
        write_word(4'd7, 16'hBEEF);
        verify(4'd7, "R5 write discarded after wrds");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule